// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is an 18-bit first-in first-out buffer whose write side and read side run on unrelated clocks. The write side reports full, half-full and a programmable almost-full level. The read side reports empty and a programmable almost-empty level. Pointers cross between the domains as Gray code through two-flop synchronizers. Depth is a power-of-two parameter between 64 and 4096 words.

Two threshold values set the almost levels. They are loaded and read back through the ordinary data buses while the load input is low. Successive load writes, and successive load reads, alternate between the almost-empty threshold and the almost-full threshold, starting with almost-empty. A mode input selects how the two almost flags are produced. In one mode each flag is registered in its own domain from synchronized pointers. In the other mode each flag is decoded directly from both raw pointers, with no synchronizer in the path.

A retransmit strobe in the read domain sets the read pointer back to location zero, so that the stored stream can be read out again.

Top module: `flagged_async_fifo`

## Requirements
- R1: After reset, empty_n=0, full_n=1, half_n=1, almost_empty_n=0 and almost_full_n=1. Both thresholds hold 7, and both load sequences start at the almost-empty threshold.
- R2: On a rising wr_clk edge with wr_n=0, load_n=1 and full_n=1, din is stored. Stored words are read out in the order they were written.
- R3: On a rising rd_clk edge with rd_n=0, load_n=1 and empty_n=1, the next stored word appears on dout. A read while empty_n=0 changes neither dout nor the read position.
- R4: full_n goes low on the write edge that stores the DEPTH-th unread word. A write while full_n=0 is dropped.
- R5: empty_n is registered on rd_clk. It goes low on the read that takes the last word. It goes high within a few read clocks after a write.
- R6: half_n (active low) is registered on wr_clk. It is low while more than DEPTH/2 words are stored.
- R7: With load_n=0, a write edge with wr_n=0 stores din[$clog2(DEPTH):0] into a threshold register, first almost-empty and then almost-full, alternating. The data array, the write position and empty_n are left unchanged.
- R8: With load_n=0, a read edge with rd_n=0 puts a threshold, zero-extended, on dout. The order alternates almost-empty then almost-full, independently of the write-side order.
- R9: almost_empty_n is 0 when the stored count is less than or equal to the almost-empty threshold, and 1 otherwise.
- R10: almost_full_n is 0 when the free space (DEPTH minus count) is less than or equal to the almost-full threshold, and 1 otherwise.
- R11: With async_flags=1, the almost flags follow both raw pointers combinationally and change right after the edge that moves a pointer. With async_flags=0, they are registered in their own domain from synchronized pointers.
- R12: A one-cycle pulse of retx on rd_clk sets the read position to location 0 and takes priority over a read in the same cycle. Reading then replays the stream from its first word. This holds when no more than DEPTH words have been written since reset and the write side is idle around the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, held across several edges of both clocks |
| wr_clk | input | 1 | Write-domain clock |
| wr_n | input | 1 | Write enable, active low |
| din | input | 18 | Write data, or threshold value during a load |
| full_n | output | 1 | Full flag, active low, wr_clk domain |
| half_n | output | 1 | Half-full flag, active low, wr_clk domain |
| almost_full_n | output | 1 | Programmable almost-full flag, active low |
| rd_clk | input | 1 | Read-domain clock |
| rd_n | input | 1 | Read enable, active low |
| dout | output | 18 | Read data, or threshold value after a load read |
| empty_n | output | 1 | Empty flag, active low, rd_clk domain |
| almost_empty_n | output | 1 | Programmable almost-empty flag, active low |
| load_n | input | 1 | Threshold access select, active low |
| async_flags | input | 1 | 1: almost flags decoded from raw pointers; 0: registered |
| retx | input | 1 | Retransmit strobe, rd_clk domain |

## Verification
The bench fills the buffer to the limit and pushes one more word. A design that stored the extra word would overwrite the oldest entry and break the drained sequence. It probes the half, almost-full and almost-empty thresholds on both sides of each boundary, so an off-by-one comparison shows up as a flag one word early or late. It loads thresholds with load_n low and then confirms that the buffer is still empty and that the readback order alternates. A design that leaked load writes into the array, or that shared one sequence pointer between the two sides, fails these checks. In asynchronous mode it samples the almost-empty flag a few nanoseconds after a write edge, before a synchronized path could respond. It also replays the stream after a retransmit, which catches a rewind that lands anywhere other than location zero.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Which threshold register the next load access targets
  typedef enum logic {
    OFS_AE = 1'b0,
    OFS_AF = 1'b1
  } ofs_sel_e;

  localparam int OFS_RESET_VAL = 7;
endpackage

// File: rtl/pf_gray_sync.sv
// Two-flop synchronizer for a Gray-coded pointer, with binary decode
module pf_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  // bit g of the binary value is the parity of Gray bits g and above
  for (genvar g = 0; g < W; g++) begin : g_dec
    assign bin_out[g] = ^stage2[W-1:g];
  end
endmodule

// File: rtl/pf_dp_ram.sv
// Simple dual-port memory: one write port, one registered read port
module pf_dp_ram #(
  parameter int DW = 18,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pf_wr_ctrl.sv
// Write-domain control: pointer, full, half-full, almost-full, threshold loads
module pf_wr_ctrl
  import pf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_n,
  input  logic                       load_n,
  input  logic [$clog2(DEPTH):0]     ofs_in,
  input  logic [$clog2(DEPTH):0]     rptr_gray,
  output logic [$clog2(DEPTH):0]     wptr,
  output logic [$clog2(DEPTH):0]     wptr_gray,
  output logic                       mem_we,
  output logic [$clog2(DEPTH)-1:0]   mem_addr,
  output logic                       full_n,
  output logic                       half_n,
  output logic                       af_sync_n,
  output logic [$clog2(DEPTH):0]     ae_off,
  output logic [$clog2(DEPTH):0]     af_off
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;
  localparam logic [OW-1:0] FULL_CNT = OW'(DEPTH);
  localparam logic [OW-1:0] HALF_CNT = OW'(DEPTH / 2);
  localparam logic [OW-1:0] OFS_RST  = OW'(OFS_RESET_VAL);

  logic [OW-1:0] rq_bin;
  logic [OW-1:0] wptr_nxt;
  logic [OW-1:0] cnt_nxt;
  logic          wr_ok;
  logic          ld_we;
  ofs_sel_e      ld_sel;

  pf_gray_sync #(.W(OW)) u_rsync (
    .clk     (clk),
    .rst     (rst),
    .gray_in (rptr_gray),
    .bin_out (rq_bin)
  );

  assign wr_ok    = !wr_n && load_n && full_n;
  assign ld_we    = !wr_n && !load_n;
  assign wptr_nxt = wptr + {{(OW-1){1'b0}}, wr_ok};
  assign cnt_nxt  = wptr_nxt - rq_bin;
  assign mem_we   = wr_ok;
  assign mem_addr = wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      wptr_gray <= '0;
      full_n    <= 1'b1;
      half_n    <= 1'b1;
      af_sync_n <= 1'b1;
      ae_off    <= OFS_RST;
      af_off    <= OFS_RST;
      ld_sel    <= OFS_AE;
    end else begin
      wptr      <= wptr_nxt;
      wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      full_n    <= (cnt_nxt != FULL_CNT);
      half_n    <= !(cnt_nxt > HALF_CNT);
      af_sync_n <= !((FULL_CNT - cnt_nxt) <= af_off);
      if (ld_we) begin
        if (ld_sel == OFS_AE) ae_off <= ofs_in;
        else                  af_off <= ofs_in;
        ld_sel <= (ld_sel == OFS_AE) ? OFS_AF : OFS_AE;
      end
    end
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wptr - rq_bin) <= FULL_CNT);

  // R6
  full_half_chk: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !half_n);

  // R7
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !wr_n) |=> $stable(wptr));

  // R7
  load_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !wr_n) |=> (ld_sel != $past(ld_sel)));
endmodule

// File: rtl/pf_rd_ctrl.sv
// Read-domain control: pointer, empty, almost-empty, retransmit, readback
module pf_rd_ctrl
  import pf_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_n,
  input  logic                       load_n,
  input  logic                       retx,
  input  logic [$clog2(DEPTH):0]     wptr_gray,
  input  logic [$clog2(DEPTH):0]     ae_off,
  input  logic [$clog2(DEPTH):0]     af_off,
  output logic [$clog2(DEPTH):0]     rptr,
  output logic [$clog2(DEPTH):0]     rptr_gray,
  output logic                       mem_re,
  output logic [$clog2(DEPTH)-1:0]   mem_addr,
  output logic                       empty_n,
  output logic                       ae_sync_n,
  output logic [DW-1:0]              rb_data,
  output logic                       rb_sel
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;

  logic [OW-1:0] wq_bin;
  logic [OW-1:0] rptr_nxt;
  logic [OW-1:0] ofs_pick;
  logic          rd_ok;
  logic          ld_re;
  ofs_sel_e      rb_ptr;

  pf_gray_sync #(.W(OW)) u_wsync (
    .clk     (clk),
    .rst     (rst),
    .gray_in (wptr_gray),
    .bin_out (wq_bin)
  );

  assign rd_ok    = !rd_n && load_n && empty_n && !retx;
  assign ld_re    = !rd_n && !load_n;
  assign mem_re   = rd_ok;
  assign mem_addr = rptr[AW-1:0];
  assign ofs_pick = (rb_ptr == OFS_AE) ? ae_off : af_off;

  always_comb begin
    rptr_nxt = rptr;
    if (retx)       rptr_nxt = '0;
    else if (rd_ok) rptr_nxt = rptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      rptr_gray <= '0;
      empty_n   <= 1'b0;
      ae_sync_n <= 1'b0;
      rb_data   <= '0;
      rb_sel    <= 1'b0;
      rb_ptr    <= OFS_AE;
    end else begin
      rptr      <= rptr_nxt;
      rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
      empty_n   <= (rptr_nxt != wq_bin);
      ae_sync_n <= !((wq_bin - rptr_nxt) <= ae_off);
      if (ld_re) begin
        rb_data <= {{(DW-OW){1'b0}}, ofs_pick};
        rb_sel  <= 1'b1;
        rb_ptr  <= (rb_ptr == OFS_AE) ? OFS_AF : OFS_AE;
      end else if (rd_ok) begin
        rb_sel  <= 1'b0;
      end
    end
  end

  // R12
  rewind_chk: assert property (@(posedge clk) disable iff (rst)
    retx |=> (rptr == '0));

  // R3
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !retx) |=> $stable(rptr));

  // R8
  readback_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !rd_n) |=> (rb_ptr != $past(rb_ptr)));
endmodule

// File: rtl/flagged_async_fifo.sv
// Dual-clock FIFO with loadable almost-empty / almost-full thresholds
module flagged_async_fifo #(
  parameter int DW    = 18,
  parameter int DEPTH = 64
) (
  input  logic          rst,
  input  logic          wr_clk,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic          full_n,
  output logic          half_n,
  output logic          almost_full_n,
  input  logic          rd_clk,
  input  logic          rd_n,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          almost_empty_n,
  input  logic          load_n,
  input  logic          async_flags,
  input  logic          retx
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;
  localparam logic [OW-1:0] FULL_CNT = OW'(DEPTH);

  logic [OW-1:0] wptr, wptr_gray, rptr, rptr_gray;
  logic [OW-1:0] ae_off, af_off, raw_cnt;
  logic [AW-1:0] waddr, raddr;
  logic          mem_we, mem_re;
  logic          af_sync_n, ae_sync_n;
  logic          ae_async_n, af_async_n;
  logic [DW-1:0] ram_q, rb_data;
  logic          rb_sel;

  pf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk       (wr_clk),
    .rst       (rst),
    .wr_n      (wr_n),
    .load_n    (load_n),
    .ofs_in    (din[OW-1:0]),
    .rptr_gray (rptr_gray),
    .wptr      (wptr),
    .wptr_gray (wptr_gray),
    .mem_we    (mem_we),
    .mem_addr  (waddr),
    .full_n    (full_n),
    .half_n    (half_n),
    .af_sync_n (af_sync_n),
    .ae_off    (ae_off),
    .af_off    (af_off)
  );

  pf_rd_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk       (rd_clk),
    .rst       (rst),
    .rd_n      (rd_n),
    .load_n    (load_n),
    .retx      (retx),
    .wptr_gray (wptr_gray),
    .ae_off    (ae_off),
    .af_off    (af_off),
    .rptr      (rptr),
    .rptr_gray (rptr_gray),
    .mem_re    (mem_re),
    .mem_addr  (raddr),
    .empty_n   (empty_n),
    .ae_sync_n (ae_sync_n),
    .rb_data   (rb_data),
    .rb_sel    (rb_sel)
  );

  pf_dp_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wr_clk),
    .we    (mem_we),
    .waddr (waddr),
    .wdata (din),
    .rclk  (rd_clk),
    .re    (mem_re),
    .raddr (raddr),
    .rdata (ram_q)
  );

  // Unsynchronized decode straight from both live pointers
  assign raw_cnt    = wptr - rptr;
  assign ae_async_n = !(raw_cnt <= ae_off);
  assign af_async_n = !((FULL_CNT - raw_cnt) <= af_off);

  assign almost_empty_n = async_flags ? ae_async_n : ae_sync_n;
  assign almost_full_n  = async_flags ? af_async_n : af_sync_n;
  assign dout           = rb_sel ? rb_data : ram_q;
endmodule

// File: tb/test_flagged_async_fifo.sv
module test_flagged_async_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DEPTH      = 64;
  localparam int DW         = 18;

  logic          rst = 1'b1;
  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_n = 1'b1;
  logic          rd_n = 1'b1;
  logic          load_n = 1'b1;
  logic          async_flags = 1'b0;
  logic          retx = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          full_n, half_n, almost_full_n, empty_n, almost_empty_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RD_PERIOD / 2)  rd_clk = ~rd_clk;

  flagged_async_fifo #(.DW(DW), .DEPTH(DEPTH)) i_flagged_async_fifo (
    .rst            (rst),
    .wr_clk         (wr_clk),
    .wr_n           (wr_n),
    .din            (din),
    .full_n         (full_n),
    .half_n         (half_n),
    .almost_full_n  (almost_full_n),
    .rd_clk         (rd_clk),
    .rd_n           (rd_n),
    .dout           (dout),
    .empty_n        (empty_n),
    .almost_empty_n (almost_empty_n),
    .load_n         (load_n),
    .async_flags    (async_flags),
    .retx           (retx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge rd_clk);
    rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; load_n = 1'b1; retx = 1'b0;
    repeat (4) @(negedge rd_clk);
    rst = 1'b0;
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic push(input int v);
    @(negedge wr_clk);
    din = DW'(v); wr_n = 1'b0;
    @(negedge wr_clk);
    wr_n = 1'b1;
  endtask

  task automatic pop(output int v);
    @(negedge rd_clk);
    rd_n = 1'b0;
    @(negedge rd_clk);
    rd_n = 1'b1;
    v = int'(dout);
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    chk("R1 empty_n", empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 half_n", half_n, 1);
    chk("R1 almost_empty_n", almost_empty_n, 0);
    chk("R1 almost_full_n", almost_full_n, 1);
    load_n = 1'b0;
    pop(v); chk("R1 default ae threshold", v, 7);
    pop(v); chk("R1 default af threshold", v, 7);
    load_n = 1'b1;
  endtask

  task automatic t_order();
    int v;
    do_reset();
    push(18'h2A5A5); push(18'h15A5A); push(18'h3FFFF);
    settle();
    chk("R5 empty_n after writes", empty_n, 1);
    pop(v); chk("R2 word 0", v, 18'h2A5A5);
    pop(v); chk("R3 word 1", v, 18'h15A5A);
    pop(v); chk("R2 word 2", v, 18'h3FFFF);
    chk("R5 empty_n on last read", empty_n, 0);
    settle();
    pop(v); chk("R3 read while empty leaves dout", v, 18'h3FFFF);
    push(55); settle();
    pop(v); chk("R3 position kept after empty read", v, 55);
  endtask

  task automatic t_fill();
    int v;
    int bad = 0;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      push(i + 1000);
      if (i + 1 == DEPTH / 2)     chk("R6 half_n at half", half_n, 1);
      if (i + 1 == DEPTH / 2 + 1) chk("R6 half_n above half", half_n, 0);
      if (i + 1 == DEPTH - 8)     chk("R10 almost_full_n free 8", almost_full_n, 1);
      if (i + 1 == DEPTH - 7)     chk("R10 almost_full_n free 7", almost_full_n, 0);
      if (i + 1 == DEPTH - 1)     chk("R4 full_n one short", full_n, 1);
    end
    chk("R4 full_n at depth", full_n, 0);
    push(18'h3ABCD);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      pop(v);
      if (v != i + 1000 && bad == 0) begin
        bad = 1;
        chk("R4 drained sequence", v, i + 1000);
      end
    end
    if (bad == 0) chk("R2 drained sequence intact", 1, 1);
    settle();
    chk("R4 extra write dropped", empty_n, 0);
  endtask

  task automatic t_load();
    int v;
    do_reset();
    load_n = 1'b0;
    push(3);
    push(9);
    load_n = 1'b1;
    settle();
    chk("R7 load leaves array empty", empty_n, 0);
    load_n = 1'b0;
    pop(v); chk("R8 readback ae", v, 3);
    pop(v); chk("R8 readback af", v, 9);
    load_n = 1'b1;
    push(100); push(101); push(102);
    settle();
    chk("R9 almost_empty_n count 3 of 3", almost_empty_n, 0);
    push(103);
    settle();
    chk("R9 almost_empty_n count 4 of 3", almost_empty_n, 1);
    for (int i = 0; i < DEPTH - 10 - 4; i++) push(200 + i);
    settle();
    chk("R10 almost_full_n free 10", almost_full_n, 1);
    push(999);
    chk("R10 almost_full_n free 9", almost_full_n, 0);
    pop(v); chk("R7 first data word intact", v, 100);
  endtask

  task automatic t_async();
    do_reset();
    async_flags = 1'b1;
    for (int i = 0; i < 7; i++) push(i);
    settle();
    chk("R11 async almost_empty_n count 7", almost_empty_n, 0);
    push(7);
    chk("R11 async almost_empty_n right after write", almost_empty_n, 1);
    do_reset();
    async_flags = 1'b0;
    for (int i = 0; i < 8; i++) push(i);
    chk("R11 sync almost_empty_n not yet updated", almost_empty_n, 0);
    settle();
    chk("R11 sync almost_empty_n after sync", almost_empty_n, 1);
  endtask

  task automatic t_retx();
    int v;
    do_reset();
    push(11); push(22); push(33); push(44);
    settle();
    pop(v); chk("R12 pre word 0", v, 11);
    pop(v); chk("R12 pre word 1", v, 22);
    @(negedge rd_clk); retx = 1'b1;
    @(negedge rd_clk); retx = 1'b0;
    pop(v); chk("R12 replay word 0", v, 11);
    pop(v); chk("R12 replay word 1", v, 22);
    pop(v); chk("R12 replay word 2", v, 33);
    pop(v); chk("R12 replay word 3", v, 44);
    settle();
    chk("R12 empty after replay", empty_n, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_fill();
    t_load();
    t_async();
    t_retx();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule